// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits at the front of a DDR SDRAM controller and steps the memory through its mandatory start-up sequence. After a synchronous reset it holds the clock enable low with NOP on the command pins through a long settling wait. It then raises the clock enable and issues seven commands in a fixed order: precharge all banks, load the extended mode register, load the mode register with the DLL reset bit set, a second precharge-all, two auto-refreshes, and a final mode register load with the DLL reset bit cleared. Each command is followed by the wait its type requires.

A configuration input, sampled while reset is high, moves the two auto-refreshes ahead of the second precharge-all. The mode and extended mode code words are inputs, and every delay is a parameter with a floor of one cycle. The `initDone` flag tells the rest of the controller when row activation may begin. A separate `readOk` flag counts the DLL lock window from the DLL-reset write and gates reads on its own, whatever the state of `initDone`.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is released, `ddrCke` stays low for exactly PWR_WAIT cycles, with NOP on `ddrCmdN` throughout. It then goes high for one NOP cycle, and the first precharge-all appears on the next cycle.
- R2: With `arEarly` low during reset, exactly seven commands are issued in this order: PRE, EMRS, MRS (DLL reset), PRE, AR, AR, MRS (final).
- R3: With `arEarly` high during reset, the order is PRE, EMRS, MRS (DLL reset), AR, AR, PRE, MRS (final).
- R4: `ddrCmdN` carries {cs_n, ras_n, cas_n, we_n}. NOP is 4'b0111, PRE is 4'b0010, AR is 4'b0001, and both MRS and EMRS are 4'b0000. Activate has the reserved code 4'b0011 and is never issued by the block.
- R5: PRE drives `ddrAddr` bit 10 high, all other address bits low and `ddrBa` = 2'b00. EMRS drives `ddrBa` = 2'b01 (bit 0 is BA0 high, bit 1 is BA1 low) and `ddrAddr` = `emrsCode`. Each MRS drives `ddrBa` = 2'b00 and `ddrAddr` = `modeCode`, with bit 8 forced to 1 in the DLL-reset write and to 0 in the final write.
- R6: Each command follows the previous one by exactly T_RP cycles after a PRE, T_MRD cycles after an EMRS or MRS, and T_RFC cycles after an AR.
- R7: `initDone` rises exactly T_MRD cycles after the final MRS and stays high until the next reset. From then on only NOP is driven, with `ddrCke` high.
- R8: `readOk` rises exactly DLL_WIN cycles after the DLL-reset MRS and stays high until reset. It may rise before or after `initDone`.
- R9: While `rst` is high, the outputs are `ddrCke` = 0, NOP, `initDone` = 0 and `readOk` = 0. A reset asserted in the middle of the sequence restarts it from the settling wait.
- R10: Any timing parameter set below 1 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| arEarly | input | 1 | Order select, sampled during reset: 1 places both auto-refreshes before the second precharge-all |
| modeCode | input | ADDR_W | Mode register code word (bit 8 is overridden) |
| emrsCode | input | ADDR_W | Extended mode register code word |
| ddrCke | output | 1 | Clock enable to the memory |
| ddrCmdN | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ddrBa | output | 2 | Bank address, bit 0 is BA0 |
| ddrAddr | output | ADDR_W | Address pins |
| initDone | output | 1 | Initialization complete; row activation permitted |
| readOk | output | 1 | DLL lock window elapsed; reads permitted |

## Verification
Two instances run side by side. One has distinct, unequal delays and a DLL window longer than the remaining sequence, so an off-by-one in any single gap shows up and `initDone` arrives before `readOk`. The other has every parameter at or below one, so the clamp and back-to-back issue are exercised and `readOk` arrives before `initDone`. Random mode and extended-mode code words, including ones with bit 8 already set or already clear, separate a forced bit 8 from a passed-through one. Random values of the order select, together with resets asserted at random points mid-sequence, tell the two command orders apart and show that a reset restarts the sequence cleanly.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_AR  = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_NOP = 4'b0111
  } ddrCmdE;

  typedef enum logic [2:0] {
    K_PRE,
    K_EMRS,
    K_MRS_DLL,
    K_AR,
    K_MRS_FIN
  } stepKindE;

  // Strobes from control to datapath
  typedef struct packed {
    logic     ckeOn;
    logic     issue;
    stepKindE kind;
    logic     doneSet;
  } seqStrobeT;

  localparam int NUM_STEPS = 7;

endpackage

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      arEarly,
  input  logic      gapZero,
  output seqStrobeT strobe
);

  typedef enum logic [1:0] {S_PWR, S_RUN, S_FIN, S_DONE} phaseE;

  localparam int STEP_W = $clog2(NUM_STEPS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  phaseE             phase, phaseNxt;
  logic [STEP_W-1:0] step, stepNxt;
  logic              earlyQ;

  // Which command belongs to each step, for both orders
  function automatic stepKindE kindOf(input logic early, input logic [STEP_W-1:0] s);
    stepKindE k;
    case (s)
      STEP_W'(0): k = K_PRE;
      STEP_W'(1): k = K_EMRS;
      STEP_W'(2): k = K_MRS_DLL;
      STEP_W'(3): k = early ? K_AR : K_PRE;
      STEP_W'(4): k = K_AR;
      STEP_W'(5): k = early ? K_PRE : K_AR;
      default:    k = K_MRS_FIN;
    endcase
    return k;
  endfunction

  always_comb begin
    phaseNxt       = phase;
    stepNxt        = step;
    strobe.ckeOn   = 1'b0;
    strobe.issue   = 1'b0;
    strobe.kind    = kindOf(earlyQ, step);
    strobe.doneSet = 1'b0;
    case (phase)
      S_PWR: begin
        if (gapZero) begin
          strobe.ckeOn = 1'b1;
          phaseNxt     = S_RUN;
        end
      end
      S_RUN: begin
        if (gapZero) begin
          strobe.issue = 1'b1;
          stepNxt      = step + STEP_W'(1);
          if (step == LAST_STEP) phaseNxt = S_FIN;
        end
      end
      S_FIN: begin
        if (gapZero) begin
          strobe.doneSet = 1'b1;
          phaseNxt       = S_DONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= S_PWR;
      step   <= '0;
      earlyQ <= arEarly;
    end else begin
      phase  <= phaseNxt;
      step   <= stepNxt;
    end
  end

endmodule

// File: rtl/ddr_init_dpath.sv
module ddr_init_dpath
  import ddr_init_pkg::*;
#(
  parameter int PWR_WAIT = 25000,
  parameter int T_MRD    = 2,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 10,
  parameter int DLL_WIN  = 200,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobeT         strobe,
  input  logic [ADDR_W-1:0] modeCode,
  input  logic [ADDR_W-1:0] emrsCode,
  output logic              gapZero,
  output logic              ddrCke,
  output logic [3:0]        ddrCmdN,
  output logic [1:0]        ddrBa,
  output logic [ADDR_W-1:0] ddrAddr,
  output logic              initDone,
  output logic              readOk
);

  localparam int PWR_E = (PWR_WAIT < 1) ? 1 : PWR_WAIT;
  localparam int MRD_E = (T_MRD    < 1) ? 1 : T_MRD;
  localparam int RP_E  = (T_RP     < 1) ? 1 : T_RP;
  localparam int RFC_E = (T_RFC    < 1) ? 1 : T_RFC;
  localparam int DLL_E = (DLL_WIN  < 1) ? 1 : DLL_WIN;
  localparam int MAX_A = (PWR_E > MRD_E) ? PWR_E : MRD_E;
  localparam int MAX_B = (RP_E  > RFC_E) ? RP_E  : RFC_E;
  localparam int MAX_G = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_G + 2);
  localparam int DLL_W = $clog2(DLL_E + 1);
  localparam int AP_BIT  = 10;
  localparam int DLL_BIT = 8;

  logic [CNT_W-1:0] gapCnt;
  logic [DLL_W-1:0] dllCnt;
  logic             dllArmed;

  // Spacing that follows each command kind
  function automatic logic [CNT_W-1:0] gapLoad(input stepKindE k);
    logic [CNT_W-1:0] g;
    case (k)
      K_PRE:   g = CNT_W'(RP_E - 1);
      K_AR:    g = CNT_W'(RFC_E - 1);
      default: g = CNT_W'(MRD_E - 1);
    endcase
    return g;
  endfunction

  assign gapZero = (gapCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt <= CNT_W'(PWR_E);
    end else if (strobe.ckeOn) begin
      gapCnt <= '0;
    end else if (strobe.issue) begin
      gapCnt <= gapLoad(strobe.kind);
    end else if (!gapZero) begin
      gapCnt <= gapCnt - CNT_W'(1);
    end
  end

  // DLL lock window, independent of the command sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      dllCnt   <= '0;
      dllArmed <= 1'b0;
      readOk   <= 1'b0;
    end else if (strobe.issue && strobe.kind == K_MRS_DLL) begin
      dllCnt   <= DLL_W'(DLL_E - 1);
      dllArmed <= 1'b1;
    end else if (dllArmed) begin
      if (dllCnt == '0) begin
        readOk   <= 1'b1;
        dllArmed <= 1'b0;
      end else begin
        dllCnt <= dllCnt - DLL_W'(1);
      end
    end
  end

  // Pin registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ddrCke   <= 1'b0;
      ddrCmdN  <= CMD_NOP;
      ddrBa    <= 2'b00;
      ddrAddr  <= '0;
      initDone <= 1'b0;
    end else begin
      if (strobe.ckeOn)   ddrCke   <= 1'b1;
      if (strobe.doneSet) initDone <= 1'b1;
      ddrCmdN <= CMD_NOP;
      ddrBa   <= 2'b00;
      ddrAddr <= '0;
      if (strobe.issue) begin
        case (strobe.kind)
          K_PRE: begin
            ddrCmdN         <= CMD_PRE;
            ddrAddr[AP_BIT] <= 1'b1;
          end
          K_EMRS: begin
            ddrCmdN <= CMD_MRS;
            ddrBa   <= 2'b01;
            ddrAddr <= emrsCode;
          end
          K_MRS_DLL: begin
            ddrCmdN          <= CMD_MRS;
            ddrAddr          <= modeCode;
            ddrAddr[DLL_BIT] <= 1'b1;
          end
          K_AR: begin
            ddrCmdN <= CMD_AR;
          end
          default: begin
            ddrCmdN          <= CMD_MRS;
            ddrAddr          <= modeCode;
            ddrAddr[DLL_BIT] <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int PWR_WAIT = 25000,
  parameter int T_MRD    = 2,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 10,
  parameter int DLL_WIN  = 200,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arEarly,
  input  logic [ADDR_W-1:0] modeCode,
  input  logic [ADDR_W-1:0] emrsCode,
  output logic              ddrCke,
  output logic [3:0]        ddrCmdN,
  output logic [1:0]        ddrBa,
  output logic [ADDR_W-1:0] ddrAddr,
  output logic              initDone,
  output logic              readOk
);

  seqStrobeT strobe;
  logic      gapZero;

  ddr_init_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .arEarly (arEarly),
    .gapZero (gapZero),
    .strobe  (strobe)
  );

  ddr_init_dpath #(
    .PWR_WAIT (PWR_WAIT),
    .T_MRD    (T_MRD),
    .T_RP     (T_RP),
    .T_RFC    (T_RFC),
    .DLL_WIN  (DLL_WIN),
    .ADDR_W   (ADDR_W)
  ) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .modeCode (modeCode),
    .emrsCode (emrsCode),
    .gapZero  (gapZero),
    .ddrCke   (ddrCke),
    .ddrCmdN  (ddrCmdN),
    .ddrBa    (ddrBa),
    .ddrAddr  (ddrAddr),
    .initDone (initDone),
    .readOk   (readOk)
  );

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int T_MRD  = 2,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ddrCke,
  input logic [3:0]        ddrCmdN,
  input logic [1:0]        ddrBa,
  input logic [ADDR_W-1:0] ddrAddr,
  input logic              initDone,
  input logic              readOk
);

  localparam int MRD_E = (T_MRD < 1) ? 1 : T_MRD;
  localparam int RP_E  = (T_RP  < 1) ? 1 : T_RP;
  localparam int RFC_E = (T_RFC < 1) ? 1 : T_RFC;
  localparam int MIN_A = (MRD_E < RP_E) ? MRD_E : RP_E;
  localparam int MIN_G = (MIN_A < RFC_E) ? MIN_A : RFC_E;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] MRS = 4'b0000;

  logic [3:0] cmdCount;
  int         sinceLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdCount  <= '0;
      sinceLast <= 0;
    end else begin
      if (ddrCmdN != NOP) begin
        cmdCount  <= cmdCount + 4'd1;
        sinceLast <= 1;
      end else if (sinceLast < 1000) begin
        sinceLast <= sinceLast + 1;
      end
    end
  end

  a_r1_cke_low_nop: assert property (@(posedge clk) disable iff (rst)
    !ddrCke |-> ddrCmdN == NOP);

  a_r2_at_most_seven: assert property (@(posedge clk) disable iff (rst)
    ddrCmdN != NOP |-> cmdCount < 4'd7);

  a_r5_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
    ddrCmdN == PRE |-> ddrAddr[10] && ddrBa == 2'b00);

  a_r5_mrs_ba1_low: assert property (@(posedge clk) disable iff (rst)
    ddrCmdN == MRS |-> ddrBa[1] == 1'b0);

  a_r6_min_gap: assert property (@(posedge clk) disable iff (rst)
    (ddrCmdN != NOP && cmdCount != 4'd0) |-> sinceLast >= MIN_G);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    initDone |-> (ddrCmdN == NOP && ddrCke && cmdCount == 4'd7));

  a_r8_read_sticky: assert property (@(posedge clk) disable iff (rst)
    readOk |=> readOk);

endmodule

bind ddr_init_seq ddr_init_chk #(
  .T_MRD  (T_MRD),
  .T_RP   (T_RP),
  .T_RFC  (T_RFC),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ddrCke   (ddrCke),
  .ddrCmdN  (ddrCmdN),
  .ddrBa    (ddrBa),
  .ddrAddr  (ddrAddr),
  .initDone (initDone),
  .readOk   (readOk)
);

// File: tb/ddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_init_seq_tb_top;

  // Instance 0: distinct delays; instance 1: everything clamped to one
  localparam int A_PWR = 12, A_MRD = 2, A_RP = 3, A_RFC = 5, A_DLL = 40;
  localparam int B_PWR = 0,  B_MRD = 0, B_RP = 1, B_RFC = 0, B_DLL = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arEarly = 1'b0;
  logic [11:0] modeCode = '0;
  logic [11:0] emrsCode = '0;

  logic        cke   [2];
  logic [3:0]  cmd   [2];
  logic [1:0]  ba    [2];
  logic [11:0] addr  [2];
  logic        done  [2];
  logic        rdOk  [2];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ddr_init_seq #(.PWR_WAIT(A_PWR), .T_MRD(A_MRD), .T_RP(A_RP), .T_RFC(A_RFC),
                 .DLL_WIN(A_DLL), .ADDR_W(12)) dut_i (
    .clk(clk), .rst(rst), .arEarly(arEarly), .modeCode(modeCode), .emrsCode(emrsCode),
    .ddrCke(cke[0]), .ddrCmdN(cmd[0]), .ddrBa(ba[0]), .ddrAddr(addr[0]),
    .initDone(done[0]), .readOk(rdOk[0]));

  ddr_init_seq #(.PWR_WAIT(B_PWR), .T_MRD(B_MRD), .T_RP(B_RP), .T_RFC(B_RFC),
                 .DLL_WIN(B_DLL), .ADDR_W(12)) dut_min_i (
    .clk(clk), .rst(rst), .arEarly(arEarly), .modeCode(modeCode), .emrsCode(emrsCode),
    .ddrCke(cke[1]), .ddrCmdN(cmd[1]), .ddrBa(ba[1]), .ddrAddr(addr[1]),
    .initDone(done[1]), .readOk(rdOk[1]));

  function automatic int clamp1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int pPwr(input int i); return clamp1(i == 0 ? A_PWR : B_PWR); endfunction
  function automatic int pMrd(input int i); return clamp1(i == 0 ? A_MRD : B_MRD); endfunction
  function automatic int pRp (input int i); return clamp1(i == 0 ? A_RP  : B_RP);  endfunction
  function automatic int pRfc(input int i); return clamp1(i == 0 ? A_RFC : B_RFC); endfunction
  function automatic int pDll(input int i); return clamp1(i == 0 ? A_DLL : B_DLL); endfunction

  // kinds: 0 PRE, 1 EMRS, 2 MRS with DLL reset, 3 AR, 4 final MRS
  function automatic int expKind(input bit early, input int s);
    int normal[7] = '{0, 1, 2, 0, 3, 3, 4};
    int moved [7] = '{0, 1, 2, 3, 3, 0, 4};
    return early ? moved[s] : normal[s];
  endfunction

  function automatic logic [3:0] kindCmd(input int k);
    case (k)
      0: return 4'b0010;
      3: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [11:0] kindAddr(input int k, input logic [11:0] m, input logic [11:0] e);
    logic [11:0] a;
    case (k)
      0: a = 12'h400;
      1: a = e;
      2: begin a = m; a[8] = 1'b1; end
      3: a = 12'h000;
      default: begin a = m; a[8] = 1'b0; end
    endcase
    return a;
  endfunction

  function automatic logic [1:0] kindBa(input int k);
    return (k == 1) ? 2'b01 : 2'b00;
  endfunction

  function automatic int kindGap(input int i, input int k);
    case (k)
      0: return pRp(i);
      3: return pRfc(i);
      default: return pMrd(i);
    endcase
  endfunction

  // Port monitor, sampling at the falling edge
  int          sIdx;
  int          nCmd   [2];
  int          cTime  [2][8];
  logic [3:0]  cCmd   [2][8];
  logic [11:0] cAddr  [2][8];
  logic [1:0]  cBa    [2][8];
  int          ckeT   [2];
  int          doneT  [2];
  int          readT  [2];
  int          lowBad [2];
  int          dropCnt[2];
  int          ckeFall[2];

  always @(negedge clk) begin
    if (rst) begin
      sIdx = 0;
      for (int i = 0; i < 2; i++) begin
        nCmd[i] = 0; ckeT[i] = -1; doneT[i] = -1; readT[i] = -1;
        lowBad[i] = 0; dropCnt[i] = 0; ckeFall[i] = 0;
      end
    end else begin
      sIdx++;
      for (int i = 0; i < 2; i++) begin
        if (ckeT[i] < 0 && cke[i]) ckeT[i] = sIdx;
        if (ckeT[i] >= 0 && !cke[i]) ckeFall[i]++;
        if (!cke[i] && cmd[i] != 4'b0111) lowBad[i]++;
        if (cmd[i] != 4'b0111) begin
          if (nCmd[i] < 8) begin
            cTime[i][nCmd[i]] = sIdx;
            cCmd[i][nCmd[i]]  = cmd[i];
            cAddr[i][nCmd[i]] = addr[i];
            cBa[i][nCmd[i]]   = ba[i];
          end
          nCmd[i]++;
        end
        if (doneT[i] < 0 && done[i]) doneT[i] = sIdx;
        if (doneT[i] >= 0 && !done[i]) dropCnt[i]++;
        if (readT[i] < 0 && rdOk[i]) readT[i] = sIdx;
        if (readT[i] >= 0 && !rdOk[i]) dropCnt[i]++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkRun(input int i, input bit early, input logic [11:0] m, input logic [11:0] e);
    int t, k, mrsCnt, preCnt, arCnt, tDll;
    string ordTag, tmTag;
    ordTag = early ? "R3 order" : "R2 order";
    tmTag  = (i == 1) ? "R10 clamped gap" : "R6 gap";
    chk(ckeT[i] == pPwr(i) + 1, "R1 cke rise", ckeT[i], pPwr(i) + 1);
    chk(lowBad[i] == 0 && ckeFall[i] == 0, "R1 nop while cke low", lowBad[i] + ckeFall[i], 0);
    chk(nCmd[i] == 7, "R2 command count", nCmd[i], 7);
    t = pPwr(i) + 2;
    tDll = -1;
    mrsCnt = 0; preCnt = 0; arCnt = 0;
    for (int s = 0; s < 7 && s < nCmd[i]; s++) begin
      k = expKind(early, s);
      if (cCmd[i][s] == 4'b0000) mrsCnt++;
      if (cCmd[i][s] == 4'b0010) preCnt++;
      if (cCmd[i][s] == 4'b0001) arCnt++;
      chk(cCmd[i][s] == kindCmd(k), ordTag, cCmd[i][s], kindCmd(k));
      chk(cAddr[i][s] == kindAddr(k, m, e), "R5 address", cAddr[i][s], kindAddr(k, m, e));
      chk(cBa[i][s] == kindBa(k), "R5 bank", cBa[i][s], kindBa(k));
      chk(cTime[i][s] == t, (s == 0) ? "R1 first precharge" : tmTag, cTime[i][s], t);
      if (k == 2) tDll = t;
      t = t + kindGap(i, k);
    end
    chk(mrsCnt == 3 && preCnt == 2 && arCnt == 2, "R4 encodings",
        mrsCnt * 100 + preCnt * 10 + arCnt, 322);
    chk(doneT[i] == t, "R7 done timing", doneT[i], t);
    chk(readT[i] == tDll + pDll(i), "R8 read window", readT[i], tDll + pDll(i));
    chk(dropCnt[i] == 0 && done[i] && rdOk[i], "R7 R8 flags held", dropCnt[i], 0);
    if (i == 0) chk(readT[i] > doneT[i], "R8 read after done", readT[i], doneT[i] + 1);
    else        chk(readT[i] < doneT[i], "R8 read before done", readT[i], doneT[i] - 1);
  endtask

  task automatic runTrial(input bit early, input logic [11:0] m, input logic [11:0] e,
                          input int runCycles, input bit full);
    @(negedge clk); #1;
    rst = 1'b1; arEarly = early; modeCode = m; emrsCode = e;
    repeat (3) @(negedge clk);
    #1;
    for (int i = 0; i < 2; i++)
      chk(!cke[i] && cmd[i] == 4'b0111 && !done[i] && !rdOk[i], "R9 reset state",
          {cke[i], cmd[i], done[i], rdOk[i]}, 7'b0011100);
    rst = 1'b0;
    repeat (runCycles) @(negedge clk);
    #1;
    if (full) begin
      checkRun(0, early, m, e);
      checkRun(1, early, m, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed: both orders, bit 8 preset high and low
    runTrial(1'b0, 12'h133, 12'h002, 120, 1'b1);
    runTrial(1'b1, 12'h032, 12'hFFF, 120, 1'b1);
    // directed: reset in mid-sequence, then a full run (R9 restart)
    runTrial(1'b1, 12'h0A5, 12'h001, 17, 1'b0);
    runTrial(1'b0, 12'h0A5, 12'h001, 120, 1'b1);
    // random codes, orders and mid-sequence resets
    for (int n = 0; n < 12; n++) begin
      logic [11:0] m, e;
      bit early;
      m = 12'($urandom);
      e = 12'($urandom);
      early = 1'($urandom);
      if ((n % 3) == 2) runTrial(early, m, e, 2 + ($urandom % 40), 1'b0);
      runTrial(early, m, e, 120, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule